// File: doc/BRIEF.md
# Burst-Mode Wait-State Generator

This block drives the wait request of a processor bus that samples its wait line on every falling clock edge. The strobe-to-sample window on that bus is too short for a DRAM controller's own wait output to change state in time. So the wait level comes from a local register. The block's own logic is clocked on the rising edge of `clk_i`, and the registered output is stable well before the next falling edge, where the processor samples it.

The start of each bus cycle is marked by a one-cycle address-strobe pulse, and that pulse asserts the wait request. In a normal access the request stays asserted until the controller's early half-cycle acknowledge is registered, which gives exactly one wait state. In a burst access the first word is released the same way. After that, each falling edge of the data strobe marks a finished word, and the register toggles: it asserts the wait request for one cycle and then drops it by itself, so each following word gets exactly one wait state. Once the last word of the burst (`BURST_LEN`, four by default) has finished, the request stays deasserted until the next address strobe.

Top module: `burst_wait_gen`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first address strobe, `wait_o` is 0 (deasserted).
- R2: A rising clock edge that samples `as_i` = 1 sets `wait_o` to 1 after that edge. This holds whatever the other inputs are.
- R3: When `wait_o` = 1 and no burst word has finished yet, `wait_o` stays 1 across edges that sample `ack_i` = 0. It goes to 0 after the first edge that samples `ack_i` = 1.
- R4: When `wait_o` = 0 and no burst reassertion is due, `ack_i` = 1 has no effect: `wait_o` stays 0.
- R5: With `burst_i` = 1, a data-strobe falling edge sets `wait_o` to 1 for exactly one cycle when fewer than `BURST_LEN`-1 words have finished. A falling edge is an edge that samples `ds_i` = 0 after the previous edge sampled `ds_i` = 1. After that one cycle, `wait_o` returns to 0 without any acknowledge.
- R6: The data-strobe falling edge that finishes word `BURST_LEN` of a burst does not assert `wait_o`. Later falling edges do not assert it either, until the next address strobe.
- R7: With `burst_i` = 0, data-strobe falling edges never assert `wait_o`.
- R8: An address strobe restarts the word count. A burst that follows it again receives `BURST_LEN`-1 reassertions, even if the strobe arrives in the middle of a burst or on the same edge as a data-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; logic updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe, a one-cycle pulse at the start of a bus cycle |
| ds_i | input | 1 | Data strobe level, high while a word transfer is active |
| ack_i | input | 1 | Early half-cycle acknowledge from the DRAM controller |
| burst_i | input | 1 | High while the current bus cycle is a burst |
| wait_o | output | 1 | Registered wait request, 1 = insert a wait state |

## Verification
A normal access is run with the acknowledge held off for several cycles, which separates an acknowledge-driven release from a fixed one-cycle release. Data-strobe toggling is then repeated with the burst indicator low and with it high, which shows that reassertion depends on burst mode. A full burst checks that there are three one-cycle reassertions, that the wait request falls by itself after each one, and that it stays quiet after the fourth word and on a later strobe fall. A burst interrupted by an address strobe on the same edge as a strobe fall, followed by a second full burst, shows whether the word count restarts or carries over.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int unsigned DEF_BURST_LEN = 4;

  // per-edge control events seen by the wait register
  typedef struct packed {
    logic start;     // address strobe sampled
    logic ack;       // early acknowledge sampled
    logic first;     // no burst word finished yet
    logic reassert;  // burst word finished, more to come
  } wsg_evt_t;
endpackage

// File: rtl/wsg_ds_edge.sv
module wsg_ds_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ds_i,
  output logic fall_o
);
  logic ds_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ds_q <= 1'b0;
    else         ds_q <= ds_i;
  end

  assign fall_o = ds_q & ~ds_i;
endmodule

// File: rtl/wsg_beat_cnt.sv
module wsg_beat_cnt #(
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             burst_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             first_o,
  output logic             reassert_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BURST_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  assign inc        = burst_i & fall_i & (cnt_q != FULL);
  assign reassert_o = ~start_i & inc & (cnt_q < LAST);
  assign first_o    = (cnt_q == '0);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (inc)     cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);  // R6
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0));  // R8
  AST_NO_COUNT_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_i && !start_i) |=> $stable(cnt_q));  // R7
endmodule

// File: rtl/wsg_wait_reg.sv
module wsg_wait_reg
  import wsg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wsg_evt_t evt_i,
  output logic     wait_o
);
  logic wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             wait_q <= 1'b0;
    else if (evt_i.start)    wait_q <= 1'b1;
    else if (wait_q) begin
      // first word waits for ack; burst words self-clear after one cycle
      if (!evt_i.first || evt_i.ack) wait_q <= 1'b0;
    end
    else if (evt_i.reassert) wait_q <= 1'b1;
  end

  assign wait_o = wait_q;

  AST_START_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.start |=> wait_q);  // R2
  AST_HOLD_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && evt_i.first && !evt_i.ack) |=> wait_q);  // R3
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !evt_i.start && evt_i.ack) |=> !wait_q);  // R3
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !evt_i.start && !evt_i.first) |=> !wait_q);  // R5
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && !evt_i.start && !evt_i.reassert) |=> !wait_q);  // R4
endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
  import wsg_pkg::*;
#(
  parameter int unsigned BURST_LEN = DEF_BURST_LEN,
  localparam int unsigned CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_i,
  input  logic ds_i,
  input  logic ack_i,
  input  logic burst_i,
  output logic wait_o
);
  logic             ds_fall;
  logic [CNT_W-1:0] cnt;
  logic             first;
  logic             reassert;
  wsg_evt_t         evt;

  wsg_ds_edge i_ds_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ds_i   (ds_i),
    .fall_o (ds_fall)
  );

  wsg_beat_cnt #(.BURST_LEN(BURST_LEN)) i_beat_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (as_i),
    .burst_i    (burst_i),
    .fall_i     (ds_fall),
    .cnt_o      (cnt),
    .first_o    (first),
    .reassert_o (reassert)
  );

  assign evt.start    = as_i;
  assign evt.ack      = ack_i;
  assign evt.first    = first;
  assign evt.reassert = reassert;

  wsg_wait_reg i_wait_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .wait_o (wait_o)
  );

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_i && !wait_o && cnt >= CNT_W'(BURST_LEN - 1)) |=> !wait_o);  // R6
  AST_NORMAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_i && !burst_i && !wait_o) |=> !wait_o);  // R7
endmodule

// File: tb/test_burst_wait_gen.sv
module test_burst_wait_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic as_i = 1'b0, ds_i = 1'b0, ack_i = 1'b0, burst_i = 1'b0;
  logic wait_o;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  typedef struct { bit exp; string req; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  burst_wait_gen i_burst_wait_gen (
    .clk_i(clk), .rst_ni(rst_ni), .as_i(as_i), .ds_i(ds_i),
    .ack_i(ack_i), .burst_i(burst_i), .wait_o(wait_o)
  );

  // monitor: compare after each rising edge settles
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (wait_o !== it.exp) begin
        bad++;
        $display("FAIL %s: wait_o=%0b expected=%0b", it.req, wait_o, it.exp);
      end
    end
  end

  // driver: apply one cycle of inputs, push expected wait_o after next edge
  task automatic step(input bit a, input bit d, input bit k, input bit b,
                      input bit exp, input string req);
    item_t it;
    @(negedge clk);
    as_i = a; ds_i = d; ack_i = k; burst_i = b;
    it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // finish one burst word chain after first-word release: ds is high
  task automatic burst_words(input string req);
    for (int w = 0; w < 3; w++) begin
      step(0, 0, 0, 1, 1'b1, "R5");   // falling ds -> one wait cycle
      step(0, 0, 0, 1, 1'b0, "R5");   // self clears
      step(0, 1, 0, 1, 1'b0, req);
    end
    step(0, 0, 0, 1, 1'b0, "R6");     // fourth word: no reassert
    step(0, 1, 0, 1, 1'b0, "R6");
    step(0, 0, 1, 1, 1'b0, "R6");     // later fall, ack: still quiet
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (wait_o !== 1'b0) begin
      bad++; $display("FAIL R1: wait_o=%0b expected=0 in reset", wait_o);
    end
    @(negedge clk) rst_ni = 1'b1;
    step(0, 0, 0, 0, 1'b0, "R1");
    step(0, 0, 1, 0, 1'b0, "R4");

    // normal access, ack delayed
    step(1, 0, 0, 0, 1'b1, "R2");
    step(0, 1, 0, 0, 1'b1, "R3");
    step(0, 1, 0, 0, 1'b1, "R3");
    step(0, 1, 1, 0, 1'b0, "R3");
    step(0, 0, 0, 0, 1'b0, "R7");
    step(0, 1, 1, 0, 1'b0, "R4");
    step(0, 0, 0, 0, 1'b0, "R7");

    // full burst
    step(1, 0, 1, 1, 1'b1, "R2");     // strobe wins over ack
    step(0, 1, 0, 1, 1'b1, "R3");
    step(0, 1, 1, 1, 1'b0, "R3");
    burst_words("R5");

    // burst cut by a new strobe on a ds fall
    step(1, 0, 0, 1, 1'b1, "R2");
    step(0, 1, 1, 1, 1'b0, "R3");
    step(0, 0, 0, 1, 1'b1, "R5");
    step(0, 0, 0, 1, 1'b0, "R5");
    step(0, 1, 0, 1, 1'b0, "R8");
    step(1, 0, 0, 1, 1'b1, "R8");     // strobe with fall: restart
    step(0, 1, 0, 1, 1'b1, "R8");
    step(0, 1, 1, 1, 1'b0, "R8");
    burst_words("R8");
    step(0, 0, 0, 0, 1'b0, "R7");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule